// File: doc/BRIEF.md
# Register-Mapped Serial Flash Master

This block is a single-device serial peripheral interface master with a word-wide register port. Software puts one word into a one-entry transmit slot, programs a length code and the clock-mode fields in the command register, and sets the start bit. The engine then shifts between 8 and 32 bits out on the data-out pin, most significant bit first. It samples the data-in pin on the edge chosen by the phase field and leaves the received bits, right-aligned, in a one-entry receive slot.

Completion is reported through a sticky ready flag in the status register. That register also carries live occupancy flags and two sticky error flags: one for a write into an already occupied transmit slot and one for a read of an empty receive slot. Software clears any sticky flag by writing a 1 to its position, so writing back the value it read clears every pending event.

The device select is either held by software through a level bit, with the pin driven low when the bit is 1, or driven low by hardware for the length of a transfer. The serial clock comes from a parameterised divider of the system clock and only toggles while a transfer runs.

Top module: `sfm_master`

## Requirements
- R1: After reset the command register reads 0, the status register reads 0x02800000 (both slots empty, not busy, not ready), the select pin is high and the serial clock is low.
- R2: Writing the command register (byte offset 0x00) with bit 30 set starts a transfer that gives exactly 2×N serial clock edges. The low N bits of the transmit word appear on data-out MSB first. At the end, busy (status bit 31) clears and ready (status bit 30) sets on the same clock.
- R3: With receive enabled, the N sampled bits are right-aligned in the receive slot (offset 0x20) and status bit 24 (receive full) is set. Reading the slot returns the word and sets status bit 25 (receive empty).
- R4: Command bits [4:0] hold N−1, so codes 7 and 31 give 8-bit and 32-bit transfers.
- R5: A nonzero command field [27:26] makes the idle clock high. A nonzero field [19:18] moves sampling to the trailing edge, and zero samples on the leading edge.
- R6: With command bit 12 set, the select pin equals the inverse of command bit 13. With bit 12 clear, the pin is low exactly while a transfer is busy.
- R7: Writing 1 to status bits 30, 27 or 26 clears that flag. Writing 0 leaves it set.
- R8: Writing the transmit slot (offset 0x10) while it holds a word sets status bit 26 and keeps the pending word. Status bits 22/23 show the slot full/empty, and a finished transfer empties it.
- R9: Reading an empty receive slot returns 0 and sets status bit 27.
- R10: With command bit 15 clear, data-out stays 0. With bit 14 clear, the receive slot is not loaded. Data-out is 0 whenever no transfer is busy.
- R11: Command writes made while busy are ignored, including a new start bit.
- R12: While no transfer is busy, the serial clock rests at the idle level and shows no edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on the receive slot) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low device select |

## Verification
The assertions check several invariants on every cycle. The clock rests at the idle level and data-out is low whenever the engine is idle. The select pin follows the software bit, or is low while busy under hardware control. Ready rises on the clock where busy falls, the command register stays stable through a transfer, and an overflowing transmit write raises its flag. The bench scenarios show what only a peer on the wire can see. These are the bit order and the edge count for each clock mode and length, right alignment of short words, the content of the receive slot, the write-one-to-clear semantics, and that the pending word survives an overflow.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
   // command register bit positions (software-visible contract)
   localparam int CMD_GO      = 30;
   localparam int CMD_POL_LO  = 26;
   localparam int CMD_PHA_LO  = 18;
   localparam int CMD_TXEN    = 15;
   localparam int CMD_RXEN    = 14;
   localparam int CMD_CSVAL   = 13;
   localparam int CMD_CSSOFT  = 12;
   localparam int LEN_W       = 5;

   // status register bit positions
   localparam int ST_BUSY = 31;
   localparam int ST_RDY  = 30;
   localparam int ST_RUNR = 27;
   localparam int ST_TOVF = 26;
   localparam int ST_REMP = 25;
   localparam int ST_RFUL = 24;
   localparam int ST_TEMP = 23;
   localparam int ST_TFUL = 22;

   // byte offsets
   localparam logic [5:0] OFF_CMD  = 6'h00;
   localparam logic [5:0] OFF_STAT = 6'h04;
   localparam logic [5:0] OFF_TX   = 6'h10;
   localparam logic [5:0] OFF_RX   = 6'h20;

   typedef struct packed {
      logic [1:0]       pol;
      logic [1:0]       pha;
      logic             tx_en;
      logic             rx_en;
      logic             cs_val;
      logic             cs_soft;
      logic [LEN_W-1:0] len;
   } cmd_t;

   function automatic cmd_t cmd_unpack(input logic [31:0] w);
      cmd_t c;
      c.pol     = w[CMD_POL_LO+1:CMD_POL_LO];
      c.pha     = w[CMD_PHA_LO+1:CMD_PHA_LO];
      c.tx_en   = w[CMD_TXEN];
      c.rx_en   = w[CMD_RXEN];
      c.cs_val  = w[CMD_CSVAL];
      c.cs_soft = w[CMD_CSSOFT];
      c.len     = w[LEN_W-1:0];
      return c;
   endfunction

   function automatic logic [31:0] cmd_pack(input cmd_t c);
      logic [31:0] w;
      w = '0;
      w[CMD_POL_LO+1:CMD_POL_LO] = c.pol;
      w[CMD_PHA_LO+1:CMD_PHA_LO] = c.pha;
      w[CMD_TXEN]   = c.tx_en;
      w[CMD_RXEN]   = c.rx_en;
      w[CMD_CSVAL]  = c.cs_val;
      w[CMD_CSSOFT] = c.cs_soft;
      w[LEN_W-1:0]  = c.len;
      return w;
   endfunction
endpackage

// File: rtl/sfm_tick.sv
module sfm_tick #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("sfm_tick: DIV_HALF must be at least 1");
      end
      if (DIV_HALF == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(DIV_HALF);
         localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (!run)         cnt <= '0;
            else if (cnt == LAST)  cnt <= '0;
            else                   cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/sfm_shift.sv
module sfm_shift #(
   parameter int WORD_W = 32,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic [LEN_W-1:0]  start_len,
   input  logic              start_cpol,
   input  logic              start_cpha,
   input  logic              start_txen,
   input  logic [WORD_W-1:0] start_word,
   input  logic              idle_pol,
   input  logic              miso,
   output logic              busy,
   output logic              run,
   output logic              done,
   output logic              sclk,
   output logic              mosi,
   output logic [WORD_W-1:0] rx_word
);
   localparam int EW = LEN_W + 1;

   initial begin
      if (WORD_W != (1 << LEN_W)) $error("sfm_shift: WORD_W must equal 2**LEN_W");
   end

   logic [WORD_W-1:0] sr;
   logic [EW-1:0]     edge_idx, edge_last;
   logic              ph, fin, cpol_q, cpha_q, txen_q;

   assign run  = busy && !fin;
   assign done = fin;
   assign sclk = busy ? (cpol_q ^ ph) : idle_pol;
   assign mosi = busy && txen_q && sr[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; fin <= 1'b0; ph <= 1'b0;
         sr <= '0; rx_word <= '0;
         edge_idx <= '0; edge_last <= '0;
         cpol_q <= 1'b0; cpha_q <= 1'b0; txen_q <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            busy      <= 1'b1;
            ph        <= 1'b0;
            sr        <= start_word << (WORD_W - 1 - int'(start_len));
            rx_word   <= '0;
            edge_idx  <= '0;
            edge_last <= {start_len, 1'b1};
            cpol_q    <= start_cpol;
            cpha_q    <= start_cpha;
            txen_q    <= start_txen;
         end
      end else if (fin) begin
         busy <= 1'b0;
         fin  <= 1'b0;
      end else if (tick) begin
         ph       <= ~ph;
         edge_idx <= edge_idx + 1'b1;
         if (edge_idx[0] == cpha_q)
            rx_word <= {rx_word[WORD_W-2:0], miso};
         else if (!(cpha_q && edge_idx == '0))
            sr <= sr << 1;
         if (edge_idx == edge_last) fin <= 1'b1;
      end
   end
endmodule

// File: rtl/sfm_master.sv
module sfm_master #(
   parameter int DIV_HALF = 2,
   parameter int ADDR_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n
);
   import sfm_pkg::*;

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("sfm_master: ADDR_W must cover offset 0x20");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(OFF_TX);
   localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(OFF_RX);

   cmd_t        cmd_q, cmd_new;
   logic [31:0] tx_word, rx_hold, eng_rx, status;
   logic        tx_valid, rx_valid, ready, runr, tovf;
   logic        busy, run, tick, done, start, idle_pol;
   logic        wr_cmd, wr_stat, wr_tx, rd_rx;

   assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
   assign wr_stat = bus_wr && (bus_addr == A_STAT);
   assign wr_tx   = bus_wr && (bus_addr == A_TX);
   assign rd_rx   = bus_rd && (bus_addr == A_RX);
   assign cmd_new = cmd_unpack(bus_wdata);
   assign start   = wr_cmd && !busy && bus_wdata[CMD_GO];
   assign idle_pol = |cmd_q.pol;

   sfm_tick #(.DIV_HALF(DIV_HALF)) i_tick (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
   );

   sfm_shift #(.WORD_W(32), .LEN_W(LEN_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
      .start_len(cmd_new.len), .start_cpol(|cmd_new.pol),
      .start_cpha(|cmd_new.pha), .start_txen(cmd_new.tx_en),
      .start_word(tx_word), .idle_pol(idle_pol), .miso(spi_miso),
      .busy(busy), .run(run), .done(done), .sclk(spi_sclk),
      .mosi(spi_mosi), .rx_word(eng_rx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         tx_word <= '0; tx_valid <= 1'b0;
         rx_hold <= '0; rx_valid <= 1'b0;
         ready <= 1'b0; runr <= 1'b0; tovf <= 1'b0;
      end else begin
         if (wr_cmd && !busy) cmd_q <= cmd_new;
         if (wr_stat) begin
            if (bus_wdata[ST_RDY])  ready <= 1'b0;
            if (bus_wdata[ST_RUNR]) runr  <= 1'b0;
            if (bus_wdata[ST_TOVF]) tovf  <= 1'b0;
         end
         if (wr_tx) begin
            if (tx_valid) tovf <= 1'b1;
            else begin
               tx_word  <= bus_wdata;
               tx_valid <= 1'b1;
            end
         end
         if (rd_rx) begin
            if (rx_valid) rx_valid <= 1'b0;
            else          runr     <= 1'b1;
         end
         if (done) begin
            ready    <= 1'b1;
            tx_valid <= 1'b0;
            if (cmd_q.rx_en) begin
               rx_hold  <= eng_rx;
               rx_valid <= 1'b1;
            end
         end
      end
   end

   assign spi_cs_n = cmd_q.cs_soft ? !cmd_q.cs_val : !busy;

   always_comb begin
      status = '0;
      status[ST_BUSY] = busy;
      status[ST_RDY]  = ready;
      status[ST_RUNR] = runr;
      status[ST_TOVF] = tovf;
      status[ST_REMP] = !rx_valid;
      status[ST_RFUL] = rx_valid;
      status[ST_TEMP] = !tx_valid;
      status[ST_TFUL] = tx_valid;
   end

   always_comb begin
      case (bus_addr)
         A_CMD:   bus_rdata = cmd_pack(cmd_q);
         A_STAT:  bus_rdata = status;
         A_TX:    bus_rdata = tx_word;
         A_RX:    bus_rdata = rx_valid ? rx_hold : 32'h0;
         default: bus_rdata = 32'h0;
      endcase
   end
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          sclk,
   input logic          idle_pol,
   input logic          mosi,
   input logic          cs_n,
   input sfm_pkg::cmd_t cmd_q,
   input logic          ready,
   input logic          tovf,
   input logic          tx_valid,
   input logic          wr_tx
);
   // R12: clock rests at idle level while idle
   a_r12_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk == idle_pol));
   // R10: data-out low while idle
   a_r10_mosi_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mosi);
   // R6: software-held select
   a_r6_cs_soft: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_q.cs_soft |-> (cs_n == !cmd_q.cs_val));
   // R6: hardware select low during busy
   a_r6_cs_hw: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_q.cs_soft && busy) |-> !cs_n);
   // R2: ready rises with the end of busy
   a_r2_ready_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ready);
   // R11: command frozen through a transfer
   a_r11_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cmd_q));
   // R8: overflowing write raises the flag
   a_r8_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tx && tx_valid) |=> tovf);
endmodule

bind sfm_master sfm_checker i_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(spi_sclk),
   .idle_pol(idle_pol), .mosi(spi_mosi), .cs_n(spi_cs_n),
   .cmd_q(cmd_q), .ready(ready), .tovf(tovf),
   .tx_valid(tx_valid), .wr_tx(wr_tx)
);

// File: tb/test_sfm_master.sv
module test_sfm_master;
   localparam int DIV = 2;
   localparam logic [5:0] A_CMD = 6'h00, A_ST = 6'h04, A_TX = 6'h10, A_RX = 6'h20;
   localparam logic [31:0] GO = 32'h4000_0000, TXEN = 32'h0000_8000, RXEN = 32'h0000_4000;
   localparam logic [31:0] CSV = 32'h0000_2000, CSS = 32'h0000_1000;
   localparam logic [31:0] PHA1 = 32'h0004_0000, POL2 = 32'h0800_0000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic spi_sclk, spi_mosi, spi_cs_n;
   logic spi_miso = 1'b0;

   int n_tests = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   sfm_master #(.DIV_HALF(DIV), .ADDR_W(6)) i_sfm_master (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n)
   );

   // peer model on the wire
   bit armed = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0, cs_bad = 1'b0;
   logic [31:0] s_word = '0, cap = '0;
   int s_idx = 0, edges = 0;

   always begin
      @(spi_sclk);
      #1;
      if (armed) begin
         edges++;
         if (spi_cs_n) cs_bad = 1'b1;
         if ((spi_sclk != s_cpol) ^ s_cpha) cap = {cap[30:0], spi_mosi};
         else begin
            if (s_idx >= 0) spi_miso = s_word[s_idx];
            s_idx--;
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic arm(input logic [31:0] w, input int n, input bit cpol, input bit cpha);
      s_word = w; s_cpol = cpol; s_cpha = cpha; cap = '0; edges = 0; cs_bad = 1'b0;
      if (!cpha) begin spi_miso = w[n-1]; s_idx = n - 2; end
      else begin spi_miso = 1'b0; s_idx = n - 1; end
      armed = 1'b1;
   endtask

   task automatic wait_ready();
      logic [31:0] st;
      for (int i = 0; i < 2000; i++) begin
         reg_read(A_ST, st);
         if (st[30]) break;
      end
   endtask

   task automatic xfer(input logic [31:0] cfg, input logic [31:0] tx, input logic [31:0] sw, input int n);
      reg_write(A_CMD, cfg);
      reg_write(A_TX, tx);
      arm(sw, n, |cfg[27:26], |cfg[19:18]);
      reg_write(A_CMD, cfg | GO);
      wait_ready();
      armed = 1'b0;
   endtask

   function automatic logic [31:0] lowbits(input logic [31:0] w, input int n);
      return (n == 32) ? w : (w & ((32'h1 << n) - 1));
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      reg_read(A_ST, d);  check(d == 32'h0280_0000, "R1 status", d, 32'h0280_0000);
      reg_read(A_CMD, d); check(d == 32'h0, "R1 command", d, 32'h0);
      check(spi_cs_n == 1'b1, "R1 select", {31'b0, spi_cs_n}, 32'h1);
      check(spi_sclk == 1'b0, "R1 clock", {31'b0, spi_sclk}, 32'h0);
   endtask

   task automatic t_basic();
      logic [31:0] d;
      xfer(TXEN | RXEN | 32'd31, 32'hA5C3_0F96, 32'h3C5A_9617, 32);
      check(cap == 32'hA5C3_0F96, "R2 data-out MSB first", cap, 32'hA5C3_0F96);
      check(edges == 64, "R2 edge count", edges, 64);
      check(!cs_bad, "R6 hardware select low during transfer", {31'b0, cs_bad}, 0);
      reg_read(A_ST, d); check(d == 32'h4180_0000, "R2 R3 status after transfer", d, 32'h4180_0000);
      reg_read(A_RX, d); check(d == 32'h3C5A_9617, "R3 receive word", d, 32'h3C5A_9617);
      reg_read(A_ST, d); check(d == 32'h4280_0000, "R3 receive emptied", d, 32'h4280_0000);
      reg_write(A_ST, 32'h4000_0000);
      reg_read(A_ST, d); check(d == 32'h0280_0000, "R7 ready cleared", d, 32'h0280_0000);
   endtask

   task automatic t_len();
      logic [31:0] d;
      xfer(TXEN | RXEN | 32'd7, 32'h1234_5678, 32'h0000_00B1, 8);
      check(cap == 32'h78, "R4 8-bit data-out", cap, 32'h78);
      check(edges == 16, "R4 8-bit edges", edges, 16);
      reg_read(A_RX, d); check(d == 32'hB1, "R4 R3 right-aligned receive", d, 32'hB1);
      reg_write(A_ST, 32'hFFFF_FFFF);
   endtask

   task automatic t_modes();
      logic [31:0] d, cfg;
      int e;
      for (int m = 1; m < 4; m++) begin
         cfg = TXEN | RXEN | 32'd15 | ((m & 2) ? POL2 : 32'h0) | ((m & 1) ? PHA1 : 32'h0);
         reg_write(A_CMD, cfg);
         check(spi_sclk == ((m & 2) != 0), "R5 idle level", {31'b0, spi_sclk}, (m & 2) != 0);
         xfer(cfg, 32'h0000_C3A5 + m, 32'h0000_5AE1 + m, 16);
         check(cap == lowbits(32'h0000_C3A5 + m, 16), "R5 data-out in mode", cap, 32'h0000_C3A5 + m);
         e = edges;
         reg_read(A_RX, d); check(d == 32'h0000_5AE1 + m, "R5 receive in mode", d, 32'h0000_5AE1 + m);
         armed = 1'b1;
         repeat (20) @(negedge clk);
         armed = 1'b0;
         check(edges == e, "R12 no edges while idle", edges, e);
         reg_write(A_ST, 32'hFFFF_FFFF);
      end
   endtask

   task automatic t_cs();
      reg_write(A_CMD, CSS | CSV);
      #1 check(spi_cs_n == 1'b0, "R6 soft select low", {31'b0, spi_cs_n}, 0);
      reg_write(A_CMD, CSS);
      #1 check(spi_cs_n == 1'b1, "R6 soft select high", {31'b0, spi_cs_n}, 1);
      reg_write(A_CMD, 32'h0);
   endtask

   task automatic t_ovf();
      logic [31:0] d;
      reg_write(A_TX, 32'h0000_00AA);
      reg_write(A_TX, 32'h0000_0055);
      reg_read(A_ST, d); check(d == 32'h0640_0000, "R8 overflow flag", d, 32'h0640_0000);
      reg_write(A_CMD, TXEN | RXEN | 32'd7);
      arm(32'h0, 8, 1'b0, 1'b0);
      reg_write(A_CMD, TXEN | RXEN | 32'd7 | GO);
      wait_ready();
      armed = 1'b0;
      check(cap == 32'hAA, "R8 pending word kept", cap, 32'hAA);
      reg_read(A_RX, d);
      reg_read(A_ST, d);
      reg_write(A_ST, d);
      reg_read(A_ST, d); check(d == 32'h0280_0000, "R7 write-back clears all", d, 32'h0280_0000);
   endtask

   task automatic t_unr();
      logic [31:0] d;
      reg_read(A_RX, d); check(d == 32'h0, "R9 empty read returns zero", d, 0);
      reg_read(A_ST, d); check(d[27], "R9 underrun flag", d, 32'h0A80_0000);
      reg_write(A_ST, 32'h0);
      reg_read(A_ST, d); check(d[27], "R7 zero write keeps flag", d, 32'h0A80_0000);
      reg_write(A_ST, 32'h0800_0000);
      reg_read(A_ST, d); check(d == 32'h0280_0000, "R7 one clears underrun", d, 32'h0280_0000);
   endtask

   task automatic t_en();
      logic [31:0] d;
      xfer(32'd7, 32'hFFFF_FFFF, 32'h0000_00FF, 8);
      check(cap == 32'h0, "R10 data-out held low", cap, 0);
      reg_read(A_ST, d); check(d == 32'h4280_0000, "R10 receive not loaded", d, 32'h4280_0000);
      reg_write(A_ST, 32'hFFFF_FFFF);
   endtask

   task automatic t_busy();
      logic [31:0] d;
      reg_write(A_CMD, TXEN | RXEN | 32'd31);
      reg_write(A_TX, 32'h0F0F_1234);
      arm(32'h0, 32, 1'b0, 1'b0);
      reg_write(A_CMD, TXEN | RXEN | 32'd31 | GO);
      reg_write(A_CMD, CSS | 32'd7 | GO);
      wait_ready();
      armed = 1'b0;
      check(edges == 64, "R11 second start ignored", edges, 64);
      reg_read(A_CMD, d); check(d == (TXEN | RXEN | 32'd31), "R11 command unchanged", d, TXEN | RXEN | 32'd31);
      reg_read(A_RX, d);
      reg_write(A_ST, 32'hFFFF_FFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_len();
      t_modes();
      t_cs();
      t_ovf();
      t_unr();
      t_en();
      t_busy();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule